// File: doc/BRIEF.md
# Single-Byte SPI Master

This block is a register-driven SPI master that moves exactly one byte per start command and has no queueing. Software loads a transmit byte, then sets the start bit. The block shifts eight bits out on the serial data output and samples eight bits from the serial data input at the same time. The serial clock comes from a programmable divider. When the eighth bit has been sampled, the block stores the received byte, raises a ready flag and drives the interrupt line. Software reads the byte back, and that read clears the flag.

The serial clock idle level, the edge on which data is sampled, the bit order and an internal loopback path are each set by one bit of a configuration register. The block holds that configuration and the divisor fixed while a byte is in flight. A start command issued while the port is busy or disabled is dropped. The register port is a plain synchronous one: a write or read strobe, a 3-bit byte offset and 8-bit data.

Top module: `spim_byte_master`

## Requirements
- R1: After reset, every readable offset (0 to 6) returns 0, the serial clock output is low, the serial data output is low and the interrupt is low.
- R2: A write to offset 3 with bit 0 set, while the port is enabled (offset 0, bit 3 = 1) and idle, sends the byte held at offset 2 as eight serial bits. In the same transfer it gathers eight bits from the serial input into the receive register at offset 1.
- R3: Between transfers the serial clock rests at the level of offset 0 bit 1 (0 = low, 1 = high). The first edge of each bit period moves the clock away from that level.
- R4: With offset 0 bit 4 = 1, input is sampled on the first (leading) clock edge of each bit, output changes on the second edge, and the first bit is valid before the first edge. With bit 4 = 0, output changes on the leading edge and input is sampled on the trailing edge.
- R5: Offset 0 bit 2 = 0 sends and receives the most significant bit first. Bit 2 = 1 sends and receives the least significant bit first.
- R6: With offset 0 bit 0 = 1, the received byte is the transmitted byte, and the serial input pin is ignored.
- R7: With divisor N at offset 6, one serial clock period lasts 4×(N+1) system clocks. The ready flag becomes visible exactly 32×(N+1) clock edges after the edge that accepted the start.
- R8: The status byte at offset 4 holds busy in bit 1 and ready in bit 0. In the first cycle that ready reads 1, busy still reads 1. One cycle later, busy reads 0.
- R9: Reading offset 1 returns the received byte and clears the ready flag.
- R10: The interrupt output equals ready AND port enable. Clearing the enable bit masks the interrupt but leaves ready set in the status byte.
- R11: A start write made while busy is dropped. A write to offset 2 during a transfer does not change the byte being shifted.
- R12: A start write made while the port is disabled starts nothing: busy stays 0 and the serial clock stays idle.
- R13: Writes to offsets 0 and 6 are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Byte-complete interrupt |

## Verification
A serial slave model in the bench captures the output byte and drives its own byte back. It is run under all four combinations of clock idle level and sampling edge, with both bit orders and with divisors 0, 1, 2 and 255. The transmit and slave bytes are chosen to be asymmetric, so a swapped bit order, a wrong sampling edge or an off-by-one bit index each corrupt a different bit. A loopback transfer, whose slave drives a different byte, shows that the pin is really bypassed. Cycle counts from start to interrupt pin down the divider formula. Separate sequences issue start, transmit, mode and divisor writes during a transfer or while the port is disabled, to show that each is ignored.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int REG_W  = 8;
    localparam int REG_AW = 3;

    // Register byte offsets
    localparam logic [REG_AW-1:0] OFS_MODE = 3'd0;
    localparam logic [REG_AW-1:0] OFS_RXD  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_TXD  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd4;
    localparam logic [REG_AW-1:0] OFS_DIV  = 3'd6;

    // Configuration byte, bit 4 down to bit 0
    typedef struct packed {
        logic samp_lead;   // 1: sample on leading edge
        logic en;          // port enable
        logic lsb_first;   // bit order
        logic cpol;        // idle level of the serial clock
        logic loop_back;   // internal return path
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic [REG_W-1:0] pack_status(input logic busy, input logic ready);
        return {{(REG_W-2){1'b0}}, busy, ready};
    endfunction

endpackage

// File: rtl/spim_tick_gen.sv
module spim_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // half period in system clocks is 2*(div+1); terminal count 2*div+1
    assign half_m1 = {div, 1'b1};
    assign tick    = run && (cnt == half_m1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // half period is at least two cycles, so ticks never touch
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  mode_t             cfg,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso,
    output logic              active,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EC_W  = $clog2(EDGES + 1);
    localparam int IDX_W = $clog2(DATA_W);

    logic [EC_W-1:0]   edges;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic [EC_W-1:0]   obuf;
    logic [IDX_W-1:0]  oidx;
    logic [IDX_W-1:0]  sidx;
    logic              cpha;
    logic              sample_now;
    logic              rx_in;

    function automatic logic [IDX_W-1:0] order_pos(input logic lsb, input logic [IDX_W-1:0] i);
        return lsb ? i : IDX_W'(DATA_W - 1) - i;
    endfunction

    assign cpha = ~cfg.samp_lead;

    // bit being presented: advances on trailing edges (cpha 0) or leading edges (cpha 1)
    assign obuf = (cpha && (edges != '0)) ? edges - 1'b1 : edges;
    assign oidx = IDX_W'(obuf >> 1);
    assign sidx = IDX_W'(edges >> 1);

    assign sck  = cfg.cpol ^ edges[0];
    assign mosi = active ? tx_sh[order_pos(cfg.lsb_first, oidx)] : 1'b0;

    assign rx_in      = cfg.loop_back ? mosi : miso;
    assign sample_now = active && tick && (edges[0] == cpha);
    assign done       = active && tick && (edges == EC_W'(EDGES - 1));

    always_comb begin
        rx_next = rx_sh;
        if (sample_now) begin
            rx_next[order_pos(cfg.lsb_first, sidx)] = rx_in;
        end
    end

    assign rx_byte = rx_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            edges  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            edges  <= '0;
            tx_sh  <= tx_byte;
            rx_sh  <= '0;
        end else if (active && tick) begin
            rx_sh <= rx_next;
            if (done) begin
                active <= 1'b0;
                edges  <= '0;
            end else begin
                edges <= edges + 1'b1;
            end
        end
    end

    assert_end_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !active);

    assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> $stable(tx_sh));

endmodule

// File: rtl/spim_byte_master.sv
module spim_byte_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    mode_t             mode_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              rdy_q;
    logic              tail_q;

    logic              eng_active;
    logic              eng_done;
    logic              tick;
    logic [DATA_W-1:0] eng_rx;
    logic              busy;
    logic              start_req;
    logic              wr_cfg_ok;

    assign busy      = eng_active | tail_q;
    assign wr_cfg_ok = reg_wr && !busy;
    assign start_req = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0]
                       && mode_q.en && !busy;

    spim_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_active),
        .div  (div_q),
        .tick (tick)
    );

    spim_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start_req),
        .tick    (tick),
        .cfg     (mode_q),
        .tx_byte (tx_q),
        .miso    (miso),
        .active  (eng_active),
        .sck     (sck),
        .mosi    (mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            div_q  <= '0;
            tx_q   <= '0;
        end else begin
            if (wr_cfg_ok && reg_addr == OFS_MODE) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
            if (wr_cfg_ok && reg_addr == OFS_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
            if (reg_wr && reg_addr == OFS_TXD)     tx_q   <= reg_wdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q   <= '0;
            rdy_q  <= 1'b0;
            tail_q <= 1'b0;
        end else begin
            tail_q <= eng_done;
            if (eng_done) begin
                rx_q  <= eng_rx;
                rdy_q <= 1'b1;
            end else if (reg_rd && reg_addr == OFS_RXD) begin
                rdy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_MODE: reg_rdata = {{(REG_W-MODE_W){1'b0}}, mode_q};
            OFS_RXD:  reg_rdata = REG_W'(rx_q);
            OFS_TXD:  reg_rdata = REG_W'(tx_q);
            OFS_STAT: reg_rdata = pack_status(busy, rdy_q);
            OFS_DIV:  reg_rdata = REG_W'(div_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = rdy_q & mode_q.en;

    assert_busy_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_q) |-> busy);

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_q) |=> !busy);

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !eng_active |-> (sck == mode_q.cpol));

    assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode_q) && $stable(div_q)));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_RXD && !eng_done) |=> !irq);

    assert_disabled_start_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && !mode_q.en && !busy) |=> !eng_active);

endmodule

// File: tb/spim_byte_master_tb.sv
module spim_byte_master_tb;
    import spim_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sck, mosi, miso, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];

    // serial slave model configuration, driven only by the driver
    logic       s_on = 1'b0;
    logic       s_cpha = 1'b0;
    logic       s_lsb = 1'b0;
    logic [7:0] s_byte = '0;
    // slave model state, driven only by the monitor
    int         s_edges = 0;
    logic       s_prev = 1'b0;
    logic [7:0] s_cap = '0;
    int         s_oidx;

    always #(CLK_PERIOD/2) clk = ~clk;

    spim_byte_master u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    function automatic int bpos(input logic lsb, input int i);
        return lsb ? i : 7 - i;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // slave drives its byte, changing on the edges opposite to sampling
    always_comb begin
        if (s_cpha == 1'b0) s_oidx = s_edges / 2;
        else                s_oidx = (s_edges == 0) ? 0 : (s_edges - 1) / 2;
    end
    assign miso = s_byte[bpos(s_lsb, s_oidx)];

    // monitor: capture the output byte and compare against the scoreboard
    always @(negedge clk) begin
        logic [7:0] cap;
        logic [7:0] e;
        if (s_on && (sck !== s_prev)) begin
            cap = s_cap;
            if ((s_edges % 2) == int'(s_cpha)) cap[bpos(s_lsb, s_edges / 2)] = mosi;
            s_cap <= cap;
            if (s_edges == 15) begin
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    check(cap == e, "R2 R4 R5", "serial output byte", cap, e);
                end else begin
                    check(1'b0, "R11", "unexpected extra transfer", cap, 0);
                end
                s_edges <= 0;
            end else begin
                s_edges <= s_edges + 1;
            end
        end
        s_prev <= sck;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        reg_addr = OFS_STAT;
        n = 1;
        #1;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
            #1;
        end
    endtask

    task automatic xfer(input logic samp, input logic cpol, input logic lsb, input logic lp,
                        input int div, input logic [7:0] tx, input logic [7:0] sb,
                        input logic [7:0] exp_rx);
        logic [7:0] v;
        int n;
        wr(OFS_DIV, 8'(div));
        wr(OFS_MODE, {3'b000, samp, 1'b1, lsb, cpol, lp});
        wr(OFS_TXD, tx);
        s_cpha = ~samp; s_lsb = lsb; s_byte = sb;
        exp_q.push_back(tx);
        #1 check(sck == cpol, "R3", "idle clock level", sck, cpol);
        s_on = 1'b1;
        wr(OFS_CTRL, 8'h01);
        wait_irq(n);
        check(n == 32 * (div + 1) + 1, "R7", "cycles to ready", n, 32 * (div + 1) + 1);
        check(reg_rdata == 8'h03, "R8", "status at ready", reg_rdata, 8'h03);
        @(negedge clk);
        #1 check(reg_rdata == 8'h01, "R8", "status one cycle later", reg_rdata, 8'h01);
        check(sck == cpol, "R3", "clock back to idle", sck, cpol);
        s_on = 1'b0;
        rd(OFS_RXD, v);
        check(v == exp_rx, lp ? "R6" : "R2 R4 R5", "received byte", v, exp_rx);
        rd(OFS_STAT, v);
        check(v == 8'h00, "R9", "status after data read", v, 8'h00);
        check(irq == 1'b0, "R9", "irq after data read", irq, 0);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check(v == 8'h00, "R1", $sformatf("offset %0d after reset", a), v, 0);
        end
        check(sck == 1'b0, "R1", "sck after reset", sck, 0);
        check(mosi == 1'b0, "R1", "mosi after reset", mosi, 0);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);

        // main function across clock modes, bit orders and divisors
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 0,   8'hA5, 8'h3C, 8'h3C);
        xfer(1'b0, 1'b0, 1'b1, 1'b0, 1,   8'h0D, 8'hB2, 8'hB2);
        xfer(1'b1, 1'b1, 1'b0, 1'b0, 2,   8'hC4, 8'h5B, 8'h5B);
        xfer(1'b0, 1'b1, 1'b1, 1'b0, 0,   8'h37, 8'hE8, 8'hE8);
        xfer(1'b1, 1'b0, 1'b1, 1'b1, 255, 8'h6D, 8'h00, 8'h6D);

        // R11 and R13: writes during a transfer
        wr(OFS_DIV, 8'd1);
        wr(OFS_MODE, 8'h18);
        wr(OFS_TXD, 8'h5A);
        s_cpha = 1'b0; s_lsb = 1'b0; s_byte = 8'h96;
        exp_q.push_back(8'h5A);
        s_on = 1'b1;
        wr(OFS_CTRL, 8'h01);
        repeat (3) @(negedge clk);
        wr(OFS_TXD, 8'hFF);
        wr(OFS_CTRL, 8'h01);
        wr(OFS_DIV, 8'd7);
        wr(OFS_MODE, 8'h00);
        rd(OFS_DIV, v);
        check(v == 8'd1, "R13", "divisor write while busy", v, 1);
        rd(OFS_MODE, v);
        check(v == 8'h18, "R13", "mode write while busy", v, 8'h18);
        wait_irq(n);
        check(irq == 1'b1, "R11", "transfer completes", irq, 1);
        rd(OFS_RXD, v);
        check(v == 8'h96, "R11", "received byte unaffected", v, 8'h96);
        repeat (40) @(negedge clk);
        rd(OFS_STAT, v);
        check(v == 8'h00, "R11", "no second transfer", v, 0);
        check(exp_q.size() == 0, "R11", "original byte shifted", exp_q.size(), 0);
        s_on = 1'b0;

        // R12: start while disabled
        wr(OFS_MODE, 8'h10);
        wr(OFS_CTRL, 8'h01);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1 check(sck == 1'b0, "R12", "sck idle while disabled", sck, 0);
        end
        rd(OFS_STAT, v);
        check(v == 8'h00, "R12", "busy after disabled start", v, 0);

        // R10 and R6: interrupt masking on a loopback transfer
        wr(OFS_DIV, 8'd0);
        wr(OFS_MODE, 8'h19);
        wr(OFS_TXD, 8'h3C);
        s_cpha = 1'b0; s_lsb = 1'b0; s_byte = 8'hC1;
        exp_q.push_back(8'h3C);
        s_on = 1'b1;
        wr(OFS_CTRL, 8'h01);
        wait_irq(n);
        repeat (2) @(negedge clk);
        s_on = 1'b0;
        wr(OFS_MODE, 8'h11);
        #1 check(irq == 1'b0, "R10", "irq masked by enable", irq, 0);
        rd(OFS_STAT, v);
        check(v == 8'h01, "R10", "ready kept while masked", v, 8'h01);
        wr(OFS_MODE, 8'h19);
        #1 check(irq == 1'b1, "R10", "irq back on enable", irq, 1);
        rd(OFS_RXD, v);
        check(v == 8'h3C, "R6", "loopback byte", v, 8'h3C);
        #1 check(irq == 1'b0, "R9", "irq after read", irq, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule